// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C master. The line is open-drain, so the block either pulls it low or lets it go and watches where it ends up. Each half of the bit period has its own programmable width, counted in ticks of an operating clock. That operating clock is either the system clock or the system clock halved. A phase's count starts only after the synchronised line has actually reached the new level. Because of that, bus rise and fall times add to the period, and a slave that holds the line low stretches the high phase.

At the start of each half a one-cycle strobe fires, so a data shifter can change or sample SDA. The duty split for standard, fast or fast-plus timing comes only from the two count values. There is no mode-specific logic.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is held or `enable` is low, `scl_oe` is 0 and both strobes are 0.
- R2: With `presc_div2`=0, the line is pulled low (`scl_oe`=1) for F+3+Leff system cycles. F is the number of clock edges after the pull-down before `scl_in` is sampled low, and Leff is `low_cnt`.
- R3: With `presc_div2`=0, the line is released (`scl_oe`=0) for R+3+Heff system cycles. R is the number of clock edges after release before `scl_in` is sampled high, and Heff is `high_cnt`.
- R4: With `presc_div2`=1, the operating clock ticks on every second system cycle while a phase is counting. The counted part of each phase then lasts 2·Leff or 2·Heff system cycles.
- R5: A count value of 0 is treated as 1, so neither phase can shrink below one operating-clock cycle.
- R6: While the line is released but `scl_in` still reads low (a slave stretching the clock), the high count does not start. The high phase is lengthened by the time the line stays low.
- R7: `low_start` is 1 for exactly the first cycle of each pull-down, and `high_start` is 1 for exactly the first cycle of each release. The two are never 1 together.
- R8: Dropping `enable` releases the line and clears the strobes on the next cycle, whatever phase was in progress.
- R9: On the clock edge at which `enable` is first seen high, the block starts a new low phase. `scl_oe` and `low_start` are then 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the clock generator when high |
| presc_div2 | input | 1 | 1 selects system clock / 2 as the operating clock |
| low_cnt | input | CW | Low-phase width in operating-clock cycles (0 counts as 1) |
| high_cnt | input | CW | High-phase width in operating-clock cycles (0 counts as 1) |
| scl_in | input | 1 | Sensed SCL line level, asynchronous |
| scl_oe | output | 1 | 1 pulls SCL low, 0 lets it float high |
| low_start | output | 1 | One-cycle strobe at the start of the low phase |
| high_start | output | 1 | One-cycle strobe at the start of the high phase |

## Verification
The bench places a line model between `scl_oe` and `scl_in` that has separate fall and rise delays. It measures the pull-down and release lengths in system cycles.

The stimuli are:
- Asymmetric counts with short, unequal delays. This separates a low count from a high count and shows that the line delay is added to the phase.
- A long fall delay. This shows that counting waits for the sensed level rather than the drive edge.
- The halved operating clock, which doubles only the counted part of each phase.
- Zero counts, which must behave like one.
- A very long rise delay standing in for a stretching slave.
- Dropping `enable` mid-phase and raising it again, which shows an immediate release and a clean restart in the low phase.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LSET = 3'd1,
    PH_LCNT = 3'd2,
    PH_HSET = 3'd3,
    PH_HCNT = 3'd4
  } phase_t;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/scl_opclk_presc.sv
module scl_opclk_presc (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div2,
  output logic tick
);
  logic tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tog <= 1'b0;
    else if (run) tog <= ~tog;
    else          tog <= 1'b0;
  end

  assign tick = div2 ? tog : 1'b1;

  // R4: in the halved setting, ticks alternate while counting continues
  assert_div2_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div2 && $past(run) && $past(div2)) |-> (tick != $past(tick)));
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_clkgen_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          scl_s,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] high_cnt,
  output logic          scl_oe,
  output logic          low_start,
  output logic          high_start,
  output logic          run
);
  function automatic logic [CW-1:0] eff_count(input logic [CW-1:0] c);
    return (c == '0) ? CW'(1) : c;
  endfunction

  phase_t        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_l, lim_h;
  logic          line_low_seen, line_high_seen, low_done, high_done;

  assign lim_l          = eff_count(low_cnt);
  assign lim_h          = eff_count(high_cnt);
  assign line_low_seen  = (state == PH_LSET) && !scl_s;
  assign line_high_seen = (state == PH_HSET) && scl_s;
  assign low_done       = (state == PH_LCNT) && tick && (cnt == lim_l - CW'(1));
  assign high_done      = (state == PH_HCNT) && tick && (cnt == lim_h - CW'(1));
  assign run            = (state == PH_LCNT) || (state == PH_HCNT);
  assign scl_oe         = (state == PH_LSET) || (state == PH_LCNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      low_start  <= 1'b0;
      high_start <= 1'b0;
    end else if (!enable) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      low_start  <= 1'b0;
      high_start <= 1'b0;
    end else begin
      low_start  <= 1'b0;
      high_start <= 1'b0;
      unique case (state)
        PH_IDLE: begin
          state     <= PH_LSET;
          low_start <= 1'b1;
        end
        PH_LSET: if (line_low_seen) begin
          state <= PH_LCNT;
          cnt   <= '0;
        end
        PH_LCNT: if (low_done) begin
          state      <= PH_HSET;
          high_start <= 1'b1;
        end else if (tick) begin
          cnt <= cnt + CW'(1);
        end
        PH_HSET: if (line_high_seen) begin
          state <= PH_HCNT;
          cnt   <= '0;
        end
        PH_HCNT: if (high_done) begin
          state     <= PH_LSET;
          low_start <= 1'b1;
        end else if (tick) begin
          cnt <= cnt + CW'(1);
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_start && high_start));
  assert_low_strobe_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    low_start |-> scl_oe);
  assert_high_strobe_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |-> !scl_oe);
  assert_release_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !low_start && !high_start));
  assert_enable_starts_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (low_start && scl_oe));
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LCNT) |-> (cnt < lim_l));
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HCNT) |-> (cnt < lim_h));
  assert_stretch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_HSET) && !scl_s) |=> (state == PH_HSET || state == PH_IDLE));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          presc_div2,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] high_cnt,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          low_start,
  output logic          high_start
);
  logic scl_s, op_tick, count_run;

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(scl_in), .d_sync(scl_s)
  );

  scl_opclk_presc u_presc (
    .clk(clk), .rst_n(rst_n), .run(count_run), .div2(presc_div2), .tick(op_tick)
  );

  scl_phase_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(op_tick), .scl_s(scl_s),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_oe(scl_oe),
    .low_start(low_start), .high_start(high_start), .run(count_run)
  );

  // R1: nothing is driven while disabled
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!enable)) |-> (!scl_oe && !low_start && !high_start));
endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          presc_div2 = 1'b0;
  logic [CW-1:0] low_cnt = '0;
  logic [CW-1:0] high_cnt = '0;
  logic          line = 1'b1;
  logic          scl_oe, low_start, high_start;

  int n_chk = 0;
  int n_fail = 0;
  int fall_dly = 1;
  int rise_dly = 1;
  int fc = 0;
  int rc = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scl_clkgen #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .presc_div2(presc_div2),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_in(line),
    .scl_oe(scl_oe), .low_start(low_start), .high_start(high_start)
  );

  // Open-drain line model: separate fall and rise delays in clock edges
  always @(posedge clk) begin
    if (scl_oe) begin
      rc <= 0;
      if (line) begin
        if (fc >= fall_dly - 1) line <= 1'b0;
        else fc <= fc + 1;
      end
    end else begin
      fc <= 0;
      if (!line) begin
        if (rc >= rise_dly - 1) line <= 1'b1;
        else rc <= rc + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input bit div, input int l, input int h, input int df, input int dr);
    @(negedge clk);
    enable = 1'b0;
    repeat (40) @(negedge clk);
    presc_div2 = div;
    low_cnt    = CW'(l);
    high_cnt   = CW'(h);
    fall_dly   = df;
    rise_dly   = dr;
    enable     = 1'b1;
  endtask

  // Measures one low and one high phase from the first low strobe
  task automatic measure(input string tag, input int exp_lo, input int exp_hi);
    int g = 0;
    int lo = 0;
    int hi = 0;
    int ls_cnt = 0;
    int hs_cnt = 0;
    @(negedge clk);
    while (!low_start && g < 300) begin @(negedge clk); g++; end
    check({tag, " R7 low_start at pull-down"}, int'(low_start & scl_oe), 1);
    while (scl_oe && lo < 2000) begin
      ls_cnt += int'(low_start);
      hs_cnt += int'(high_start);
      lo++;
      @(negedge clk);
    end
    check({tag, " R7 high_start at release"}, int'(high_start), 1);
    while (!scl_oe && hi < 2000) begin
      ls_cnt += int'(low_start);
      hs_cnt += int'(high_start);
      hi++;
      @(negedge clk);
    end
    check({tag, " R7 low_start at next pull-down"}, int'(low_start), 1);
    check({tag, " R7 one low strobe"}, ls_cnt, 1);
    check({tag, " R7 one high strobe"}, hs_cnt, 1);
    check({tag, " low length"}, lo, exp_lo);
    check({tag, " high length"}, hi, exp_hi);
  endtask

  task automatic t_reset;
    check("R1 oe in reset", int'(scl_oe), 0);
    check("R1 strobes in reset", int'(low_start | high_start), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 oe while disabled", int'(scl_oe), 0);
    check("R1 strobes while disabled", int'(low_start | high_start), 0);
  endtask

  task automatic t_div1;
    setup(1'b0, 5, 4, 1, 2);
    measure("R2 R3 a", 1 + 3 + 5, 2 + 3 + 4);
    setup(1'b0, 10, 3, 3, 1);
    measure("R2 R3 b", 3 + 3 + 10, 1 + 3 + 3);
    setup(1'b0, 2, 2, 12, 1);
    measure("R2 slow fall", 12 + 3 + 2, 1 + 3 + 2);
  endtask

  task automatic t_div2;
    setup(1'b1, 4, 6, 1, 1);
    measure("R4 halved", 1 + 3 + 8, 1 + 3 + 12);
  endtask

  task automatic t_zero;
    setup(1'b0, 0, 0, 1, 1);
    measure("R5 zero counts", 5, 5);
    setup(1'b1, 0, 0, 1, 1);
    measure("R5 zero halved", 6, 6);
  endtask

  task automatic t_stretch;
    setup(1'b0, 3, 2, 1, 20);
    measure("R6 stretch", 1 + 3 + 3, 20 + 3 + 2);
  endtask

  task automatic t_disable;
    setup(1'b0, 20, 20, 1, 1);
    repeat (8) @(negedge clk);
    check("R8 mid-low drive", int'(scl_oe), 1);
    enable = 1'b0;
    @(negedge clk);
    check("R8 released", int'(scl_oe), 0);
    check("R8 strobes clear", int'(low_start | high_start), 0);
    repeat (6) @(negedge clk);
    check("R8 stays released", int'(scl_oe | low_start | high_start), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R9 restart drive", int'(scl_oe), 1);
    check("R9 restart strobe", int'(low_start), 1);
    @(negedge clk);
    check("R9 strobe single", int'(low_start), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_div1();
    t_div2();
    t_zero();
    t_stretch();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule